// File: doc/BRIEF.md
# Bit-Serial Table-Lookup FIR Filter

This block is a finite impulse response filter that contains no multipliers. Each accepted sample is captured whole and then consumed one bit per clock, least significant bit first. On every clock the current bit of each tap is gathered into an address. That address selects a precomputed sum of coefficients from a set of small constant tables. A shift-weighted accumulator adds up the table outputs, so the result is built over as many clocks as the sample has bits.

The tables are split into slices of four address bits, each with sixteen entries, and the slice outputs are summed. A parameter selects whether the sample's top bit is a two's complement sign or an ordinary magnitude bit. A second parameter selects a symmetric form. In that form, mirrored taps are added bit-serially before the lookup, which halves the table address width and costs one extra clock per result. The coefficients are fixed when the block is elaborated.

A new sample may be offered with a one-cycle strobe whenever the filter is idle. The full-precision result is then held, with a ready flag, until the next sample is taken.

Top module: `sda_fir`

## Requirements
- R1: In signed mode without symmetry, the result equals the sum over k of c_k times x_k. Here x_0 is the newest accepted sample, x_k is the k-th earlier one, samples are two's complement, and c_k is the signed field COEFS[k*CW +: CW].
- R2: In unsigned mode, every sample bit is a magnitude bit (range 0 to 2^DW-1), and the result is the same weighted sum using these values.
- R3: In symmetric mode (TAPS even), the result equals the sum for k below TAPS/2 of c_k times (x_k + x_(TAPS-1-k)). Only the lower TAPS/2 coefficient fields are used, and the pair carries start from zero for each sample.
- R4: out_ready rises exactly DW clocks after the edge that accepts a load (DW+1 clocks in symmetric mode), and never at any other time.
- R5: A load offered while a result is being computed, including on its final bit clock, is ignored. It changes neither that result nor any later one.
- R6: After reset, out_ready is 0 and out_result is 0. out_ready falls on the edge that accepts a new load. Until then, out_ready and out_result hold their values.
- R7: When every tap holds zero, the result is zero, because table address 0 always reads zero.
- R8: out_result is CW+DW+ceil(log2(TAPS)) bits wide, plus one bit in symmetric mode. Extreme inputs come out exact: the most negative sample (signed) or the all-ones sample (unsigned) against a most negative coefficient.
- R9: Taps whose addresses fall in later and partly filled table slices are weighted correctly. A unit impulse followed by zeros produces the coefficient sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_load | input | 1 | Sample strobe; taken only when idle |
| in_sample | input | DW | Sample value, captured in parallel |
| out_result | output | RW | Full-precision two's complement result |
| out_ready | output | 1 | High while out_result holds a finished value |

## Verification
The bench builds three copies of the block. Two have six taps and eight-bit data with eight-bit coefficients, one signed and one unsigned; their second table slice is only half filled. The third is signed and symmetric with ten taps, which gives five pair addresses spanning two slices and nine bit clocks per result. Together they reach the sign-bit subtraction, magnitude-only sample bits, serial pre-add carries, including a carry into the sign-extension bit, and the slice boundary. A coefficient of -128 exercises the full-precision extremes. Loads are also offered inside the busy window, including on the final bit clock, and results are taken back to back.

// File: rtl/sda_fir_pkg.sv
package sda_fir_pkg;

  localparam int SLICE_W     = 4;
  localparam int SLICE_DEPTH = 1 << SLICE_W;

  // Number of table address bits: one per tap, or one per mirrored pair.
  function automatic int addr_count(input int taps, input int sym);
    return (sym != 0) ? taps / 2 : taps;
  endfunction

  // Number of 4-bit table slices needed to cover the address bits.
  function automatic int slice_count(input int na);
    return (na + SLICE_W - 1) / SLICE_W;
  endfunction

  // Bit clocks per result: the pre-added pair sum is one bit wider.
  function automatic int bit_count(input int dw, input int sym);
    return dw + ((sym != 0) ? 1 : 0);
  endfunction

  // Full-precision result width.
  function automatic int res_width(input int cw, input int dw, input int taps, input int sym);
    return cw + dw + $clog2(taps) + ((sym != 0) ? 1 : 0);
  endfunction

  // Width of one slice entry (sum of up to four coefficients, with margin).
  function automatic int entry_width(input int cw);
    return cw + 3;
  endfunction

  // Width of the summed table output across all slices.
  function automatic int sum_width(input int cw, input int na);
    return cw + $clog2(na) + 4;
  endfunction

  // Width of the bit counter.
  function automatic int cnt_width(input int nb);
    return $clog2(nb + 1);
  endfunction

endpackage

// File: rtl/sda_fir_ctrl.sv
module sda_fir_ctrl #(
  parameter int NB   = 8,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_load,
  output logic            load_accept,
  output logic            bit_step,
  output logic            last_step,
  output logic [CNTW-1:0] bit_idx
);

  logic            busy_q;
  logic [CNTW-1:0] cnt_q;

  // Named events for the rest of the block and for the assertions.
  assign load_accept = in_load & ~busy_q;
  assign bit_step    = busy_q;
  assign last_step   = busy_q && (cnt_q == CNTW'(NB - 1));
  assign bit_idx     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last_step) begin
        busy_q <= 1'b0;
      end
      cnt_q <= cnt_q + CNTW'(1);
    end
  end

  AST_ACCEPT_STARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_accept |=> bit_step && (bit_idx == '0)); // R4

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_step && !last_step) |=> bit_step && (bit_idx == $past(bit_idx) + CNTW'(1))); // R4

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> !bit_step); // R4

endmodule

// File: rtl/sda_fir_tapline.sv
module sda_fir_tapline #(
  parameter int TAPS        = 6,
  parameter int DW          = 8,
  parameter int NA          = 6,
  parameter bit SIGNED_MODE = 1'b1,
  parameter bit SYMMETRIC   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_accept,
  input  logic          bit_step,
  input  logic [DW-1:0] in_sample,
  output logic [NA-1:0] addr_bits
);

  // line_q[j] is the (j)-th most recent accepted sample; TAPS >= 2.
  logic [TAPS-2:0][DW-1:0] line_q;
  // Serial shift registers, one per tap, reloaded on every accepted sample.
  logic [TAPS-1:0][DW-1:0] sr_q;

  // One-bit right shift; the vacated top bit repeats the sign in signed mode.
  function automatic logic [DW-1:0] shift_out(input logic [DW-1:0] w);
    return {(SIGNED_MODE ? w[DW-1] : 1'b0), w[DW-1:1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      sr_q   <= '0;
    end else if (load_accept) begin
      line_q[0] <= in_sample;
      for (int j = 1; j < TAPS - 1; j++) begin
        line_q[j] <= line_q[j-1];
      end
      sr_q[0] <= in_sample;
      for (int k = 1; k < TAPS; k++) begin
        sr_q[k] <= line_q[k-1];
      end
    end else if (bit_step) begin
      for (int k = 0; k < TAPS; k++) begin
        sr_q[k] <= shift_out(sr_q[k]);
      end
    end
  end

  generate
    if (SYMMETRIC) begin : g_sym
      logic [NA-1:0] carry_q;
      logic [NA-1:0] carry_nxt;

      for (genvar p = 0; p < NA; p++) begin : g_pair
        logic bit_a;
        logic bit_b;
        assign bit_a        = sr_q[p][0];
        assign bit_b        = sr_q[TAPS-1-p][0];
        assign addr_bits[p] = bit_a ^ bit_b ^ carry_q[p];
        assign carry_nxt[p] = (bit_a & bit_b) | (bit_a & carry_q[p]) | (bit_b & carry_q[p]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          carry_q <= '0;
        end else if (load_accept) begin
          carry_q <= '0;
        end else if (bit_step) begin
          carry_q <= carry_nxt;
        end
      end

      AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        load_accept |=> (carry_q == '0)); // R3

    end else begin : g_direct
      for (genvar k = 0; k < NA; k++) begin : g_tap
        assign addr_bits[k] = sr_q[k][0];
      end
    end
  endgenerate

  AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load_accept |=> $stable(line_q)); // R5

  AST_NEWEST_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    load_accept |=> (line_q[0] == $past(in_sample))); // R1

endmodule

// File: rtl/sda_fir_lut.sv
module sda_fir_lut
  import sda_fir_pkg::*;
#(
  parameter int               TAPS  = 6,
  parameter int               CW    = 8,
  parameter int               NA    = 6,
  parameter int               SW    = 15,
  parameter logic [TAPS*CW-1:0] COEFS = '0
) (
  input  logic [NA-1:0]        addr_bits,
  output logic signed [SW-1:0] lut_sum
);

  localparam int NS = slice_count(NA);
  localparam int EW = entry_width(CW);

  function automatic logic signed [CW-1:0] coef_at(input int k);
    return $signed(COEFS[k*CW +: CW]);
  endfunction

  // Entry a of slice s: sum of the coefficients whose address bit is set.
  function automatic logic signed [EW-1:0] slice_entry(input int s, input int a);
    logic signed [EW-1:0] total;
    logic signed [CW-1:0] c;
    total = '0;
    for (int j = 0; j < SLICE_W; j++) begin
      if (a[j] && ((s * SLICE_W + j) < NA)) begin
        c     = coef_at(s * SLICE_W + j);
        total = total + {{(EW-CW){c[CW-1]}}, c};
      end
    end
    return total;
  endfunction

  logic [NS*SLICE_W-1:0]       addr_pad;
  logic signed [EW-1:0]        slice_out [NS];

  assign addr_pad = (NS*SLICE_W)'(addr_bits);

  generate
    for (genvar s = 0; s < NS; s++) begin : g_slice
      logic signed [EW-1:0] tbl [SLICE_DEPTH];
      for (genvar a = 0; a < SLICE_DEPTH; a++) begin : g_entry
        assign tbl[a] = slice_entry(s, a);
      end
      assign slice_out[s] = tbl[addr_pad[s*SLICE_W +: SLICE_W]];
    end
  endgenerate

  always_comb begin
    lut_sum = '0;
    for (int s = 0; s < NS; s++) begin
      lut_sum = lut_sum + {{(SW-EW){slice_out[s][EW-1]}}, slice_out[s]};
    end
  end

  always_comb begin
    if (addr_bits == '0) begin
      AST_ZERO_ADDR_READS_ZERO: assert (lut_sum == '0); // R7
    end
  end

endmodule

// File: rtl/sda_fir_acc.sv
module sda_fir_acc #(
  parameter int NB          = 8,
  parameter int RW          = 19,
  parameter int SW          = 15,
  parameter int CNTW        = 4,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_accept,
  input  logic                 bit_step,
  input  logic                 last_step,
  input  logic [CNTW-1:0]      bit_idx,
  input  logic signed [SW-1:0] lut_sum,
  output logic [RW-1:0]        out_result,
  output logic                 out_ready
);

  logic signed [RW-1:0] acc_q;
  logic signed [RW-1:0] acc_nxt;
  logic signed [RW-1:0] res_q;
  logic                 rdy_q;
  logic                 sign_cycle;

  // Table term weighted by 2^idx; negated on the sign-bit clock.
  function automatic logic signed [RW-1:0] weigh(input logic signed [SW-1:0] v,
                                                input logic [CNTW-1:0]      idx,
                                                input logic                 neg);
    logic signed [RW-1:0] w;
    w = {{(RW-SW){v[SW-1]}}, v} <<< idx;
    return neg ? -w : w;
  endfunction

  assign sign_cycle = SIGNED_MODE && last_step;
  assign acc_nxt    = acc_q + weigh(lut_sum, bit_idx, sign_cycle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      rdy_q <= 1'b0;
    end else if (load_accept) begin
      acc_q <= '0;
      rdy_q <= 1'b0;
    end else if (bit_step) begin
      acc_q <= acc_nxt;
      if (last_step) begin
        res_q <= acc_nxt;
        rdy_q <= 1'b1;
      end
    end
  end

  assign out_result = res_q;
  assign out_ready  = rdy_q;

  AST_READY_CLEARED_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_accept |=> !out_ready); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !load_accept) |=> out_ready && $stable(out_result)); // R6

  AST_READY_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> $past(last_step)); // R4

endmodule

// File: rtl/sda_fir.sv
module sda_fir
  import sda_fir_pkg::*;
#(
  parameter int                 TAPS        = 6,
  parameter int                 DW          = 8,   // DW >= 5
  parameter int                 CW          = 8,
  parameter bit                 SIGNED_MODE = 1'b1,
  parameter bit                 SYMMETRIC   = 1'b0,
  parameter logic [TAPS*CW-1:0] COEFS       = {8'h01, 8'hB3, 8'h64, 8'hFB, 8'h25, 8'h80},
  localparam int                RW          = res_width(CW, DW, TAPS, int'(SYMMETRIC))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_load,
  input  logic [DW-1:0] in_sample,
  output logic [RW-1:0] out_result,
  output logic          out_ready
);

  localparam int NA   = addr_count(TAPS, int'(SYMMETRIC));
  localparam int NB   = bit_count(DW, int'(SYMMETRIC));
  localparam int SW   = sum_width(CW, NA);
  localparam int CNTW = cnt_width(NB);

  logic                 load_accept;
  logic                 bit_step;
  logic                 last_step;
  logic [CNTW-1:0]      bit_idx;
  logic [NA-1:0]        addr_bits;
  logic signed [SW-1:0] lut_sum;

  sda_fir_ctrl #(
    .NB   (NB),
    .CNTW (CNTW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_load     (in_load),
    .load_accept (load_accept),
    .bit_step    (bit_step),
    .last_step   (last_step),
    .bit_idx     (bit_idx)
  );

  sda_fir_tapline #(
    .TAPS        (TAPS),
    .DW          (DW),
    .NA          (NA),
    .SIGNED_MODE (SIGNED_MODE),
    .SYMMETRIC   (SYMMETRIC)
  ) u_tapline (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_accept (load_accept),
    .bit_step    (bit_step),
    .in_sample   (in_sample),
    .addr_bits   (addr_bits)
  );

  sda_fir_lut #(
    .TAPS  (TAPS),
    .CW    (CW),
    .NA    (NA),
    .SW    (SW),
    .COEFS (COEFS)
  ) u_lut (
    .addr_bits (addr_bits),
    .lut_sum   (lut_sum)
  );

  sda_fir_acc #(
    .NB          (NB),
    .RW          (RW),
    .SW          (SW),
    .CNTW        (CNTW),
    .SIGNED_MODE (SIGNED_MODE)
  ) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_accept (load_accept),
    .bit_step    (bit_step),
    .last_step   (last_step),
    .bit_idx     (bit_idx),
    .lut_sum     (lut_sum),
    .out_result  (out_result),
    .out_ready   (out_ready)
  );

endmodule

// File: tb/sda_fir_tb.sv
module sda_fir_lane #(
  parameter int                 TAPS        = 6,
  parameter int                 DW          = 8,
  parameter int                 CW          = 8,
  parameter bit                 SIGNED_MODE = 1'b1,
  parameter bit                 SYMMETRIC   = 1'b0,
  parameter logic [TAPS*CW-1:0] COEFS       = '0
) (
  input logic clk,
  input logic rst_n
);

  localparam int RW = sda_fir_pkg::res_width(CW, DW, TAPS, int'(SYMMETRIC));
  localparam int NB = DW + (SYMMETRIC ? 1 : 0);

  logic          in_load;
  logic [DW-1:0] in_sample;
  logic [RW-1:0] out_result;
  logic          out_ready;

  sda_fir #(
    .TAPS(TAPS), .DW(DW), .CW(CW), .SIGNED_MODE(SIGNED_MODE),
    .SYMMETRIC(SYMMETRIC), .COEFS(COEFS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_sample(in_sample),
    .out_result(out_result), .out_ready(out_ready)
  );

  int     s_run = 0;
  int     s_fail = 0;
  int     m_run = 0;
  int     m_fail = 0;
  bit     done = 1'b0;
  longint cyc = 0;
  longint last_exp = 0;
  logic   prev_rdy = 1'b0;

  logic [DW-1:0] hist [TAPS];
  longint        exp_q  [$];
  longint        when_q [$];
  string         tag_q  [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic string main_tag();
    if (SYMMETRIC) return "R3";
    if (SIGNED_MODE) return "R1";
    return "R2";
  endfunction

  function automatic longint sval(input logic [DW-1:0] r);
    if (SIGNED_MODE && r[DW-1]) return longint'(r) - (longint'(1) << DW);
    return longint'(r);
  endfunction

  function automatic longint cval(input int k);
    logic [CW-1:0] c;
    c = COEFS[k*CW +: CW];
    if (c[CW-1]) return longint'(c) - (longint'(1) << CW);
    return longint'(c);
  endfunction

  function automatic longint model_out();
    longint sum;
    sum = 0;
    if (SYMMETRIC) begin
      for (int k = 0; k < TAPS / 2; k++) sum += cval(k) * (sval(hist[k]) + sval(hist[TAPS-1-k]));
    end else begin
      for (int k = 0; k < TAPS; k++) sum += cval(k) * sval(hist[k]);
    end
    return sum;
  endfunction

  function automatic bit compare(input string tag, input longint got, input longint exp);
    if (got != exp) begin
      $display("FAIL %s (TAPS=%0d signed=%0d sym=%0d): got %0d expected %0d",
               tag, TAPS, SIGNED_MODE, SYMMETRIC, got, exp);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic chk_s(input string tag, input longint got, input longint exp);
    s_run++;
    if (compare(tag, got, exp)) s_fail++;
  endtask

  // Driver: called at a falling edge; the load is taken at the next rising edge.
  task automatic send(input logic [DW-1:0] x, input string tag, input int junk_at);
    in_load   = 1'b1;
    in_sample = x;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0]  = x;
    last_exp = model_out();
    exp_q.push_back(last_exp);
    when_q.push_back(cyc + 1 + NB);
    tag_q.push_back(tag);
    @(negedge clk);
    in_load   = 1'b0;
    in_sample = ~x;
    chk_s("R6", longint'(out_ready), 0);
    for (int i = 1; i <= NB; i++) begin
      if (i == junk_at) begin
        in_load   = 1'b1;
        in_sample = ~x;
      end
      @(negedge clk);
      in_load = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard when the ready flag rises.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_ready && !prev_rdy) begin
        m_run++;
        if (exp_q.size() == 0) begin
          if (compare("R4", 1, 0)) m_fail++;
        end else begin
          longint e;
          longint w;
          string  t;
          e = exp_q.pop_front();
          w = when_q.pop_front();
          t = tag_q.pop_front();
          if (compare(t, longint'($signed(out_result)), e)) m_fail++;
          m_run++;
          if (compare("R4", cyc, w)) m_fail++;
        end
      end
      prev_rdy <= out_ready;
    end
  end

  initial begin
    int unsigned seed;
    logic [DW-1:0] ext;
    seed      = 32'h1234_5678 + TAPS;
    in_load   = 1'b0;
    in_sample = '0;
    for (int k = 0; k < TAPS; k++) hist[k] = '0;
    @(posedge rst_n);
    @(negedge clk);
    chk_s("R6", longint'(out_ready), 0);
    chk_s("R6", longint'(out_result), 0);

    for (int n = 0; n < TAPS; n++) send('0, "R7", 0);          // R7: all taps zero

    send(DW'(1), "R9", 0);                                     // R9: impulse walks the slices
    for (int n = 1; n < TAPS; n++) send('0, "R9", 0);

    ext = SIGNED_MODE ? (DW'(1) << (DW - 1)) : '1;             // R8: extremes
    for (int n = 0; n < TAPS; n++) send(ext, "R8", 0);
    send('1, "R8", 0);

    for (int n = 0; n < 24; n++) begin                         // R1 / R2 / R3 main function
      seed = seed * 32'd1664525 + 32'd1013904223;
      send(seed[DW+7:8], main_tag(), 0);
    end

    seed = seed * 32'd1664525 + 32'd1013904223;                // R5: loads while busy
    send(seed[DW+7:8], "R5", 2);
    seed = seed * 32'd1664525 + 32'd1013904223;
    send(seed[DW+7:8], "R5", NB);
    seed = seed * 32'd1664525 + 32'd1013904223;
    send(seed[DW+7:8], "R5", 1);
    for (int n = 0; n < TAPS; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      send(seed[DW+7:8], "R5", 0);
    end

    repeat (5) @(negedge clk);                                 // R6: result held while idle
    chk_s("R6", longint'(out_ready), 1);
    chk_s("R6", longint'($signed(out_result)), last_exp);
    chk_s("R4", longint'(exp_q.size()), 0);
    done = 1'b1;
  end

endmodule

module sda_fir_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sda_fir_lane #(
    .TAPS(6), .DW(8), .CW(8), .SIGNED_MODE(1'b1), .SYMMETRIC(1'b0),
    .COEFS({8'h01, 8'hB3, 8'h64, 8'hFB, 8'h25, 8'h80})
  ) u_lane_signed (.clk(clk), .rst_n(rst_n));

  sda_fir_lane #(
    .TAPS(6), .DW(8), .CW(8), .SIGNED_MODE(1'b0), .SYMMETRIC(1'b0),
    .COEFS({8'h01, 8'hB3, 8'h64, 8'hFB, 8'h25, 8'h80})
  ) u_lane_unsigned (.clk(clk), .rst_n(rst_n));

  sda_fir_lane #(
    .TAPS(10), .DW(8), .CW(8), .SIGNED_MODE(1'b1), .SYMMETRIC(1'b1),
    .COEFS({8'h80, 8'h25, 8'hFB, 8'h64, 8'hB3, 8'hB3, 8'h64, 8'hFB, 8'h25, 8'h80})
  ) u_lane_sym (.clk(clk), .rst_n(rst_n));

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int guard;
    int tot_run;
    int tot_fail;
    guard = 0;
    while (!(u_lane_signed.done && u_lane_unsigned.done && u_lane_sym.done) && guard < WATCHDOG) begin
      @(posedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    tot_run  = u_lane_signed.s_run + u_lane_signed.m_run
             + u_lane_unsigned.s_run + u_lane_unsigned.m_run
             + u_lane_sym.s_run + u_lane_sym.m_run;
    tot_fail = u_lane_signed.s_fail + u_lane_signed.m_fail
             + u_lane_unsigned.s_fail + u_lane_unsigned.m_fail
             + u_lane_sym.s_fail + u_lane_sym.m_fail;
    if (guard >= WATCHDOG) begin
      tot_run++;
      tot_fail++;
      $display("FAIL R4 watchdog: got lanes unfinished after %0d cycles, expected all done", guard);
    end
    $display("[TB] %0d tests run, %0d failed", tot_run, tot_fail);
    $finish;
  end

endmodule